// File: doc/BRIEF.md
# Vector Element Address Sequencer

This block turns one vector memory instruction into a stream of element byte addresses. After a start pulse it captures a base address, an element size, a vector length and one of three addressing modes, then issues beats of up to four element addresses, one per 64-bit lane, together with a mask of the lanes that carry a real element. Beats move toward the memory side under a valid/ready handshake. In indexed mode the per-element offsets come in from a separate index stream, one beat's worth of four offsets per transfer.

The vector as a whole need not be aligned. Each element must sit on a multiple of its own size. The first element that breaks this rule stops generation. The sequencer raises an error flag and reports that element's number. Any lower-numbered elements of the same beat still go out.

Top module: `vec_addr_gen`

## Requirements
- R1: After reset, out_valid_o, busy_o, done_o, err_o and idx_ready_o are all 0.
- R2: Mode code 0 (unit stride): element e has address base + e * S, where S = 1, 2, 4, 8 bytes for ew_i codes 0, 1, 2, 3. Lane k of beat b carries element 4b + k, and its address sits in addr_o bits [32k+31:32k].
- R3: Mode code 1 (constant stride): element e has address base + e * stride, where stride_i is a signed byte distance. A distance of three elements, a negative distance and zero all work, and addresses wrap modulo 2^32.
- R4: Mode code 2 (indexed): element e has address base + the sign-extended 16-bit offset for e. Lane k's offset is in idx_i bits [16k+15:16k]. One beat's four offsets are consumed when idx_valid_i and idx_ready_o are both 1 on a clock edge.
- R5: A beat's mask is contiguous from lane 0 and is never empty. A run of n elements takes ceil(n/4) beats, and the final beat masks off the lanes at or beyond the vector length.
- R6: While out_valid_o is 1 and out_ready_i is 0, the next cycle still shows out_valid_o = 1 with the same addr_o and mask_o.
- R7: done_o pulses for one cycle in the cycle after the final beat is accepted. A start with vector length 0 issues no beat and pulses done_o in the cycle after the start.
- R8: When an element's address is not a multiple of its size, several things happen. err_o goes to 1 and err_elem_o gives that element's number. Only the lower-numbered elements of that beat are issued, and the beat is dropped if there are none. No later beat follows, done_o stays 0, and busy_o clears. err_o holds until the next accepted start.
- R9: A start while busy_o or out_valid_o is 1 is ignored and does not disturb the run in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a new vector access when idle |
| mode_i | input | 2 | 0 unit stride, 1 constant stride, 2 indexed |
| ew_i | input | 2 | Element size code: 0=1, 1=2, 2=4, 3=8 bytes |
| base_i | input | 32 | Base byte address |
| stride_i | input | 16 | Signed byte distance between elements (mode 1) |
| vlen_i | input | 8 | Number of elements |
| idx_valid_i | input | 1 | Index beat available |
| idx_i | input | 64 | Four signed 16-bit byte offsets, lane 0 in the low bits |
| idx_ready_o | output | 1 | Index beat is taken on this edge if valid |
| out_valid_o | output | 1 | Address beat present |
| out_ready_i | input | 1 | Memory side accepts the beat |
| addr_o | output | 128 | Four lane addresses, lane 0 in the low bits |
| mask_o | output | 4 | Lanes holding an element |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Misaligned element seen |
| err_elem_o | output | 8 | Number of the misaligned element |
| busy_o | output | 1 | Beats remain to be generated |

## Verification
On every cycle the assertions check the following. A stalled beat stays frozen. Every issued mask is a non-empty run from lane 0. Every lane the mask enables holds an aligned address. done_o appears only after an accepted beat or a zero-length start. Raising the error always ends the run. Only the bench's scenarios can show that the issued addresses are the right ones: the element numbering across beats, stride arithmetic with negative, zero and three-element distances, and index consumption in step with the beats. The same goes for the exact element an error reports, the beat count for each vector length, and a start arriving mid-run having no effect.

// File: rtl/vag_pkg.sv
package vag_pkg;

  typedef enum logic [1:0] {
    AM_UNIT   = 2'd0,
    AM_STRIDE = 2'd1,
    AM_INDEX  = 2'd2
  } amode_e;

  // bytes per element for a size code
  function automatic logic [3:0] elem_bytes(input logic [1:0] ew);
    return 4'd1 << ew;
  endfunction

  // low address bits that must be zero for a given size code
  function automatic logic lane_misaligned(input logic [2:0] lo, input logic [1:0] ew);
    logic [2:0] m;
    m = 3'(elem_bytes(ew) - 4'd1);
    return (lo & m) != 3'd0;
  endfunction

endpackage

// File: rtl/vag_lane.sv
module vag_lane
  import vag_pkg::*;
#(
  parameter int AW   = 32,
  parameter int IW   = 16,
  parameter int LANE = 0
) (
  input  amode_e          mode,
  input  logic [1:0]      ew,
  input  logic [AW-1:0]   base,
  input  logic [AW-1:0]   cur,
  input  logic [AW-1:0]   step,
  input  logic [IW-1:0]   idx,
  output logic [AW-1:0]   addr,
  output logic            mis
);
  logic [AW-1:0] lane_off;
  logic [AW-1:0] idx_ext;

  assign lane_off = step * AW'(LANE);
  assign idx_ext  = {{(AW-IW){idx[IW-1]}}, idx};
  assign addr     = (mode == AM_INDEX) ? base + idx_ext : cur + lane_off;
  assign mis      = lane_misaligned(addr[2:0], ew);
endmodule

// File: rtl/vag_first.sv
module vag_first #(
  parameter int N  = 4,
  localparam int PW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vec,
  output logic          any,
  output logic [PW-1:0] pos,
  output logic [N-1:0]  below
);
  always_comb begin
    any = 1'b0;
    pos = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        any = 1'b1;
        pos = PW'(i);
      end
    end
    for (int i = 0; i < N; i++) begin
      below[i] = !any || (PW'(i) < pos);
    end
  end
endmodule

// File: rtl/vec_addr_gen.sv
module vec_addr_gen
  import vag_pkg::*;
#(
  parameter int AW     = 32,
  parameter int LANES  = 4,
  parameter int VLEN_W = 8,
  parameter int SW     = 16,
  parameter int IW     = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [1:0]          mode_i,
  input  logic [1:0]          ew_i,
  input  logic [AW-1:0]       base_i,
  input  logic [SW-1:0]       stride_i,
  input  logic [VLEN_W-1:0]   vlen_i,
  input  logic                idx_valid_i,
  input  logic [LANES*IW-1:0] idx_i,
  output logic                idx_ready_o,
  output logic                out_valid_o,
  input  logic                out_ready_i,
  output logic [LANES*AW-1:0] addr_o,
  output logic [LANES-1:0]    mask_o,
  output logic                done_o,
  output logic                err_o,
  output logic [VLEN_W-1:0]   err_elem_o,
  output logic                busy_o
);
  localparam int CNT_W = VLEN_W + 1;
  localparam int PW    = (LANES > 1) ? $clog2(LANES) : 1;

  amode_e              mode_q;
  logic [1:0]          ew_q;
  logic [AW-1:0]       base_q, cur_q, step_q;
  logic [VLEN_W-1:0]   vlen_q;
  logic [CNT_W-1:0]    elem_q;
  logic                busy_q, ov_q, last_q, done_q, err_q;
  logic [LANES*AW-1:0] addr_q;
  logic [LANES-1:0]    mask_q;
  logic [VLEN_W-1:0]   err_elem_q;

  // named events
  logic slot_free, start_ok, zero_len_start, idx_ok, beat_load, beat_take, last_beat;
  logic [AW-1:0]       step_in;
  logic [LANES*AW-1:0] lane_bus;
  logic [LANES-1:0]    lane_mis, act;
  logic                bad_any;
  logic [PW-1:0]       bad_pos;
  logic [LANES-1:0]    bad_below;

  assign slot_free      = !ov_q || out_ready_i;
  assign start_ok       = start_i && !busy_q && !ov_q;
  assign zero_len_start = start_ok && (vlen_i == '0);
  assign idx_ok         = (mode_q != AM_INDEX) || idx_valid_i;
  assign beat_load      = busy_q && slot_free && idx_ok;
  assign beat_take      = ov_q && out_ready_i;
  assign last_beat      = (elem_q + CNT_W'(LANES)) >= {1'b0, vlen_q};
  assign idx_ready_o    = busy_q && (mode_q == AM_INDEX) && slot_free;

  always_comb begin
    case (mode_i)
      AM_UNIT:   step_in = AW'(elem_bytes(ew_i));
      AM_STRIDE: step_in = {{(AW-SW){stride_i[SW-1]}}, stride_i};
      default:   step_in = '0;
    endcase
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    vag_lane #(.AW(AW), .IW(IW), .LANE(k)) u_lane (
      .mode (mode_q),
      .ew   (ew_q),
      .base (base_q),
      .cur  (cur_q),
      .step (step_q),
      .idx  (idx_i[k*IW +: IW]),
      .addr (lane_bus[k*AW +: AW]),
      .mis  (lane_mis[k])
    );
    assign act[k] = (elem_q + CNT_W'(k)) < {1'b0, vlen_q};
  end

  vag_first #(.N(LANES)) u_first (
    .vec   (act & lane_mis),
    .any   (bad_any),
    .pos   (bad_pos),
    .below (bad_below)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q     <= AM_UNIT;
      ew_q       <= '0;
      base_q     <= '0;
      cur_q      <= '0;
      step_q     <= '0;
      vlen_q     <= '0;
      elem_q     <= '0;
      busy_q     <= 1'b0;
      ov_q       <= 1'b0;
      last_q     <= 1'b0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
      addr_q     <= '0;
      mask_q     <= '0;
      err_elem_q <= '0;
    end else begin
      done_q <= (beat_take && last_q) || zero_len_start;
      if (start_ok) begin
        mode_q     <= amode_e'(mode_i);
        ew_q       <= ew_i;
        base_q     <= base_i;
        cur_q      <= base_i;
        step_q     <= step_in;
        vlen_q     <= vlen_i;
        elem_q     <= '0;
        busy_q     <= (vlen_i != '0);
        err_q      <= 1'b0;
        err_elem_q <= '0;
      end
      if (beat_load) begin
        addr_q <= lane_bus;
        if (bad_any) begin
          ov_q       <= (bad_pos != '0);
          mask_q     <= bad_below & act;
          last_q     <= 1'b0;
          busy_q     <= 1'b0;
          err_q      <= 1'b1;
          err_elem_q <= VLEN_W'(elem_q + CNT_W'(bad_pos));
        end else begin
          ov_q   <= 1'b1;
          mask_q <= act;
          last_q <= last_beat;
          if (last_beat) busy_q <= 1'b0;
          elem_q <= elem_q + CNT_W'(LANES);
          cur_q  <= cur_q + step_q * AW'(LANES);
        end
      end else if (beat_take) begin
        ov_q <= 1'b0;
      end
    end
  end

  assign out_valid_o = ov_q;
  assign addr_o      = addr_q;
  assign mask_o      = mask_q;
  assign done_o      = done_q;
  assign err_o       = err_q;
  assign err_elem_o  = err_elem_q;
  assign busy_o      = busy_q;

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(addr_o) && $stable(mask_o)));

  // R5
  mask_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |-> ((mask_o != '0) && ((mask_o & (mask_o + LANES'(1))) == '0)));

  // R7
  done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($past(beat_take) || $past(zero_len_start)));

  // R8
  err_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> (!busy_o && !done_o));

  for (genvar k = 0; k < LANES; k++) begin : g_align_chk
    // R8
    lane_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid_o && mask_o[k]) |-> !lane_misaligned(addr_o[k*AW +: 3], ew_q));
  end
endmodule

// File: tb/vec_addr_gen_bench.sv
module vec_addr_gen_bench;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         start_i;
  logic [1:0]   mode_i, ew_i;
  logic [31:0]  base_i;
  logic [15:0]  stride_i;
  logic [7:0]   vlen_i;
  logic         idx_valid_i;
  logic [63:0]  idx_i;
  logic         idx_ready_o, out_valid_o, out_ready_i;
  logic [127:0] addr_o;
  logic [3:0]   mask_o;
  logic         done_o, err_o, busy_o;
  logic [7:0]   err_elem_o;

  int checks = 0;
  int fails  = 0;
  logic [15:0] lf = 16'hACE1;

  always #4 clk = ~clk;

  vec_addr_gen u_vec_addr_gen (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i), .ew_i(ew_i),
    .base_i(base_i), .stride_i(stride_i), .vlen_i(vlen_i), .idx_valid_i(idx_valid_i),
    .idx_i(idx_i), .idx_ready_o(idx_ready_o), .out_valid_o(out_valid_o),
    .out_ready_i(out_ready_i), .addr_o(addr_o), .mask_o(mask_o), .done_o(done_o),
    .err_o(err_o), .err_elem_o(err_elem_o), .busy_o(busy_o)
  );

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] ea(input int mode, input int ew, input logic [31:0] base,
                                     input int stride, input int e, input logic [15:0] ix);
    case (mode)
      0:       return base + 32'(e * (1 << ew));
      1:       return base + 32'(e * stride);
      default: return base + 32'($signed(ix));
    endcase
  endfunction

  task automatic run_op(input int mode, input int ew, input logic [31:0] base, input int stride,
                        input int vlen, input int bad_ix, input int rdy, input bit poke);
    logic [15:0] tab [16];
    logic [127:0] sv_addr;
    logic [3:0]   sv_mask;
    int first_bad, nv, nbeats, obs, ld, cyc, n;
    bit errcase, acc, iacc, prev_stall, exp_done, done_seen;
    string tg;
    tg = poke ? "R9" : (mode == 0 ? "R2" : (mode == 1 ? "R3" : "R4"));
    for (int e = 0; e < 16; e++) begin
      tab[e] = 16'((((e * 37) % 11) - 5) * (1 << ew));
      if (e == bad_ix) tab[e] = 16'((1 << ew) + 1);
    end
    first_bad = vlen;
    for (int e = 0; e < vlen; e++) begin
      if ((ea(mode, ew, base, stride, e, tab[e]) & 32'((1 << ew) - 1)) != 0) begin
        first_bad = e;
        break;
      end
    end
    errcase = first_bad < vlen;
    nv = first_bad;
    nbeats = (nv + 3) / 4;

    @(negedge clk);
    mode_i = 2'(mode); ew_i = 2'(ew); base_i = base; stride_i = 16'(stride);
    vlen_i = 8'(vlen); start_i = 1'b1;
    @(posedge clk);
    obs = 0; ld = 0; cyc = 0; prev_stall = 0; exp_done = 0; done_seen = 0;
    while (cyc < 300) begin
      @(negedge clk);
      start_i = 1'b0;
      if (poke && cyc == 1) begin
        start_i = 1'b1; base_i = 32'hDEAD0000; vlen_i = 8'd1; mode_i = 2'd0;
      end
      if (cyc == 0) chk(!err_o, "R8 cleared by start", err_o, 0);
      if (prev_stall) begin
        chk(out_valid_o && addr_o == sv_addr && mask_o == sv_mask, "R6", addr_o[31:0], sv_addr[31:0]);
      end
      if (out_valid_o) begin
        if (obs >= nbeats) chk(0, "R5 extra beat", obs, nbeats);
        else begin
          n = nv - obs * 4;
          if (n > 4) n = 4;
          chk(mask_o == 4'((1 << n) - 1), "R5 mask", mask_o, (1 << n) - 1);
          for (int k = 0; k < n; k++) begin
            chk(addr_o[k*32 +: 32] == ea(mode, ew, base, stride, obs*4 + k, tab[obs*4 + k]),
                tg, addr_o[k*32 +: 32], ea(mode, ew, base, stride, obs*4 + k, tab[obs*4 + k]));
          end
        end
      end
      if (cyc == 0 && vlen == 0) exp_done = 1;
      chk(done_o == exp_done, "R7", done_o, exp_done);
      if (done_o) done_seen = 1;
      if (obs == nbeats && !busy_o && !out_valid_o) break;
      out_ready_i = (rdy == 0) ? 1'b1 : lf[0];
      idx_valid_i = (rdy == 0) ? 1'b1 : (lf[1] | lf[2]);
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      for (int k = 0; k < 4; k++) idx_i[k*16 +: 16] = (ld*4 + k < 16) ? tab[ld*4 + k] : 16'h0;
      #1;
      acc  = out_valid_o && out_ready_i;
      iacc = idx_valid_i && idx_ready_o;
      prev_stall = out_valid_o && !out_ready_i;
      sv_addr = addr_o; sv_mask = mask_o;
      exp_done = acc && (obs + 1 == nbeats) && !errcase;
      if (acc) obs++;
      if (iacc) ld++;
      cyc++;
    end
    start_i = 1'b0;
    chk(cyc < 300, "R5 run ended", cyc, 0);
    chk(obs == nbeats, "R5 beat count", obs, nbeats);
    chk(err_o == errcase, "R8 flag", err_o, errcase);
    if (errcase) chk(err_elem_o == 8'(first_bad), "R8 element", err_elem_o, first_bad);
    chk(done_seen == !errcase, errcase ? "R8 no done" : "R7 done seen", done_seen, !errcase);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int vls [7] = '{0, 1, 3, 4, 5, 8, 9};
    rst_n = 1'b0; start_i = 0; mode_i = 0; ew_i = 0; base_i = 0; stride_i = 0;
    vlen_i = 0; idx_valid_i = 0; idx_i = 0; out_ready_i = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid_o && !busy_o && !done_o && !err_o && !idx_ready_o, "R1",
        {out_valid_o, busy_o, done_o, err_o, idx_ready_o}, 0);

    for (int ew = 0; ew < 4; ew++)
      foreach (vls[i]) run_op(0, ew, 32'h0000_1000, 0, vls[i], -1, ew % 2, vls[i] == 9);

    for (int ew = 0; ew < 4; ew++) begin
      int esz = 1 << ew;
      run_op(1, ew, 32'h0000_2000, 3 * esz, 7, -1, 1, 0);
      run_op(1, ew, 32'h0000_2000, -esz, 7, -1, 1, 0);
      run_op(1, ew, 32'h0000_2000, 0, 7, -1, 0, 0);
      run_op(1, ew, 32'h0000_2000, 5 * esz, 9, -1, 1, 1);
    end
    run_op(1, 0, 32'h0000_3001, 3, 9, -1, 1, 0);
    run_op(1, 1, 32'h0000_4000, 3, 6, -1, 1, 0);
    run_op(1, 2, 32'h0000_4000, 6, 8, -1, 0, 0);
    run_op(1, 3, 32'h0000_4000, -12, 8, -1, 1, 0);
    run_op(0, 2, 32'h0000_6002, 0, 5, -1, 1, 0);
    run_op(0, 1, 32'hFFFF_FFFC, 0, 5, -1, 0, 0);

    for (int ew = 0; ew < 4; ew++) begin
      run_op(2, ew, 32'h0000_8000, 0, 6, -1, 1, 0);
      run_op(2, ew, 32'h0000_8000, 0, 9, -1, 1, 1);
    end
    run_op(2, 2, 32'h0000_5000, 0, 9, 6, 1, 0);
    run_op(2, 3, 32'h0000_5000, 0, 9, 4, 0, 0);
    run_op(0, 0, 32'h0000_0100, 0, 4, -1, 0, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule